// File: doc/BRIEF.md
# Per-CPU Interrupt Interface

This block is the local interface that one processor owns inside a multiprocessor interrupt controller. It watches 32 private interrupt lines. IDs 0 to 15 are software-generated and IDs 16 to 31 are private peripheral lines. It also takes one shared request that the distributor has routed to this processor. It raises a single interrupt request toward the processor. The processor finds out what to service by reading a ready-ID register. There is no priority scheme: the lowest pending number wins, and private sources always come before the shared one.

Software controls sources through command registers that take an interrupt number as write data, not a bitmask. There are three such commands: enable, disable and completion. Each private source has its own trigger mode: level-high, level-low, rising edge or falling edge. An edge is caught by a latch that sits behind a two-flop synchronizer. A single packed write to the signal register sends an inter-processor interrupt request to the other processors. That write carries both the interrupt ID and a mask of target processors.

Top module: `cpu_irq_port`

## Requirements
- R1: After reset, `cpu_irq` is low and a read of ready-ID (offset 0x6C) returns 0x3FF. All sources are disabled, the control bit is clear and all trigger modes are level-high.
- R2: Bit 0 of the control register (offset 0x00) gates the interface. While it is clear, `cpu_irq` is low and ready-ID reads 0x3FF, whatever is pending.
- R3: Writing N (N < 32) to offset 0xA0 enables private source N. Writing N to offset 0xA4 disables it. No other source changes. A disabled source is never presented.
- R4: Each private source i has a 2-bit trigger field at bits 2i mod 32 of the word at 0x14 (i < 16) or 0x18 (i ≥ 16). The codes are 0 = level high, 1 = level low, 2 = rising edge and 3 = falling edge. The trigger words read back as written.
- R5: A read of ready-ID returns, in bits [9:0], the lowest-numbered pending private source. If no private source is pending, it returns the shared ID. If nothing is pending, it returns 0x3FF.
- R6: A read of ready-ID that returns a source marks that source active. An active source is not presented again until its number is written to the completion register (offset 0xB4).
- R7: The read that returns an edge source clears its edge latch. An edge that reaches the latch on the same clock as that read stays latched. The source is then presented again after completion.
- R8: While `shr_valid` is high and the shared source is not active, `cpu_irq` is asserted and ready-ID can return `shr_id`. Writing that ID to completion makes the shared source presentable again.
- R9: A write to offset 0x60 makes `ipi_req` high for exactly the next cycle. During that cycle `ipi_id` equals write-data bits [3:0] and `ipi_mask` equals bits [15:8].
- R10: An edge-mode source becomes pending on the third rising clock edge after its input changes. A level-mode source follows its input in the same cycle.
- R11: Reads return data in `rdata` one cycle after `rd_en`. Offset 0x00 reads the control bit, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| priv_irq | input | 32 | Private interrupt lines, IDs 0 to 31 |
| shr_valid | input | 1 | Routed shared request present |
| shr_id | input | ID_W | ID of routed shared request |
| cpu_irq | output | 1 | Interrupt request to the processor |
| ipi_req | output | 1 | One-cycle inter-processor request |
| ipi_id | output | 4 | ID carried by the request |
| ipi_mask | output | NCPU | Target processor mask |

## Verification
Two things can happen on the same clock: the ready-ID read that takes an edge source, and a new edge of that same source reaching its latch. The bench sets this up by timing a second rising edge so that the synchronized edge is detected on exactly the clock that samples the read. The read must return the source, and after completion the source must be presented and read again, not lost. The same approach also puts a completion and a new pending level in back-to-back cycles, and it checks that a private source wins over a shared request that is present at the same time.

// File: rtl/cpu_irq_port.sv
module cpu_irq_port #(
  parameter int ID_W = 8,
  parameter int NCPU = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [7:0]      addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  input  logic [31:0]     priv_irq,
  input  logic            shr_valid,
  input  logic [ID_W-1:0] shr_id,
  output logic            cpu_irq,
  output logic            ipi_req,
  output logic [3:0]      ipi_id,
  output logic [NCPU-1:0] ipi_mask
);
  localparam logic [7:0] A_CTL = 8'h00, A_TRG0 = 8'h14, A_TRG1 = 8'h18, A_SIG = 8'h60,
                         A_RDY = 8'h6C, A_SEN = 8'hA0, A_CEN = 8'hA4, A_CMP = 8'hB4;
  localparam logic [9:0] NONE = 10'h3FF;

  logic        ctl_en;
  logic [63:0] trig;
  logic [31:0] en, act, lat, s1, s2, s3;
  logic        shr_act;
  logic [ID_W-1:0] shr_tag;
  logic [31:0] pend, det;
  logic        found;
  logic [4:0]  sel;
  logic [9:0]  rdy_val;

  wire w_sen = wr_en && addr == A_SEN && wdata < 32;
  wire w_cen = wr_en && addr == A_CEN && wdata < 32;
  wire w_cmp = wr_en && addr == A_CMP;
  wire shr_pend = shr_valid && !shr_act;
  wire take = rd_en && addr == A_RDY && ctl_en;

  always_comb begin
    for (int i = 0; i < 32; i++) begin
      case (trig[2*i +: 2])
        2'd0: pend[i] = priv_irq[i];
        2'd1: pend[i] = !priv_irq[i];
        default: pend[i] = lat[i];
      endcase
      det[i] = (trig[2*i +: 2] == 2'd2 && s2[i] && !s3[i]) ||
               (trig[2*i +: 2] == 2'd3 && !s2[i] && s3[i]);
    end
    pend = pend & en & ~act;
    found = 1'b0;
    sel = '0;
    for (int i = 31; i >= 0; i--)
      if (pend[i]) begin
        found = 1'b1;
        sel = 5'(i);
      end
  end

  assign rdy_val = !ctl_en ? NONE : found ? 10'(sel) : shr_pend ? 10'(shr_id) : NONE;
  assign cpu_irq = ctl_en && (found || shr_pend);

  wire [31:0] take_bit = (take && found) ? (32'd1 << sel) : 32'd0;
  wire [31:0] done_bit = (w_cmp && wdata < 32) ? (32'd1 << wdata[4:0]) : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en <= 1'b0; trig <= '0; en <= '0; act <= '0; lat <= '0;
      s1 <= '0; s2 <= '0; s3 <= '0; shr_act <= 1'b0; shr_tag <= '0;
      rdata <= '0; ipi_req <= 1'b0; ipi_id <= '0; ipi_mask <= '0;
    end else begin
      s1 <= priv_irq; s2 <= s1; s3 <= s2;
      lat <= (lat & ~take_bit) | det;
      act <= (act & ~done_bit) | take_bit;
      if (wr_en && addr == A_CTL) ctl_en <= wdata[0];
      if (wr_en && addr == A_TRG0) trig[31:0] <= wdata;
      if (wr_en && addr == A_TRG1) trig[63:32] <= wdata;
      if (w_sen) en[wdata[4:0]] <= 1'b1;
      if (w_cen) en[wdata[4:0]] <= 1'b0;
      if (w_cmp && shr_act && wdata == 32'(shr_tag)) shr_act <= 1'b0;
      if (take && !found && shr_pend) begin
        shr_act <= 1'b1;
        shr_tag <= shr_id;
      end
      ipi_req <= wr_en && addr == A_SIG;
      if (wr_en && addr == A_SIG) begin
        ipi_id   <= wdata[3:0];
        ipi_mask <= wdata[8 +: NCPU];
      end
      if (rd_en)
        case (addr)
          A_CTL:   rdata <= {31'd0, ctl_en};
          A_TRG0:  rdata <= trig[31:0];
          A_TRG1:  rdata <= trig[63:32];
          A_RDY:   rdata <= {22'd0, rdy_val};
          default: rdata <= '0;
        endcase
    end
  end

  AST_IPI_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_req |-> $past(wr_en && addr == A_SIG)); // R9
  AST_SET_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SEN && wdata < 32) |=> en[$past(wdata[4:0])]); // R3
  AST_CLR_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CEN && wdata < 32) |=> !en[$past(wdata[4:0])]); // R3
  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTL && !wdata[0]) |=> !cpu_irq); // R2
  AST_TAKE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && found && !w_cmp) |=> act[$past(sel)]); // R6
endmodule

// File: tb/cpu_irq_port_bench.sv
module cpu_irq_port_bench;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, shr_valid = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, priv_irq = 0, rdata;
  logic [7:0] shr_id = 0, ipi_mask;
  logic cpu_irq, ipi_req;
  logic [3:0] ipi_id;
  int tests = 0, fails = 0;
  int exp_q[$];
  string tag_q[$];
  logic rd_d = 0;
  bit done = 0;

  cpu_irq_port u_cpu_irq_port (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .priv_irq(priv_irq), .shr_valid(shr_valid),
    .shr_id(shr_id), .cpu_irq(cpu_irq), .ipi_req(ipi_req), .ipi_id(ipi_id), .ipi_mask(ipi_mask));

  always #2.5 clk = ~clk;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  always @(posedge clk) rd_d <= rd_en;
  always @(negedge clk) if (rd_d && exp_q.size() > 0) chk(tag_q.pop_front(), rdata, exp_q.pop_front());

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(string r, logic [7:0] a, logic [31:0] e);
    exp_q.push_back(e); tag_q.push_back(r);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 irq after reset", cpu_irq, 0);
    rd("R1 ready after reset", 8'h6C, 32'h3FF);
    rd("R11 ctl after reset", 8'h00, 0);
    // level-high source 20 with interface off
    wr(8'hA0, 20);
    @(negedge clk) priv_irq[20] = 1;
    @(negedge clk) chk("R2 gated irq", cpu_irq, 0);
    rd("R2 gated ready", 8'h6C, 32'h3FF);
    wr(8'h00, 1);
    chk("R10 level irq", cpu_irq, 1);
    rd("R11 ctl readback", 8'h00, 1);
    priv_irq[18] = 1;
    rd("R3 disabled 18 skipped", 8'h6C, 20);
    chk("R6 active not presented", cpu_irq, 0);
    rd("R6 active ready none", 8'h6C, 32'h3FF);
    wr(8'hB4, 20);
    chk("R6 after completion", cpu_irq, 1);
    wr(8'hA0, 18);
    rd("R5 lowest wins", 8'h6C, 18);
    wr(8'hB4, 18);
    wr(8'hA4, 18);
    rd("R3 cleared 18", 8'h6C, 20);
    wr(8'hB4, 20);
    wr(8'hA4, 20);
    priv_irq[20] = 0; priv_irq[18] = 0;
    rd("R3 all idle", 8'h6C, 32'h3FF);
    // level-low on 5
    wr(8'h14, 32'h400);
    rd("R4 trig readback", 8'h14, 32'h400);
    wr(8'hA0, 5);
    rd("R4 level low", 8'h6C, 5);
    priv_irq[5] = 1;
    wr(8'hB4, 5);
    chk("R4 level low inactive", cpu_irq, 0);
    wr(8'hA4, 5);
    priv_irq[5] = 0;
    wr(8'h14, 32'hC0);
    // rising edge on 17: word 0x18 bits 3:2
    wr(8'h18, 32'h8);
    wr(8'hA0, 17);
    @(negedge clk) priv_irq[17] = 1;
    @(negedge clk) chk("R10 edge 1", cpu_irq, 0);
    @(negedge clk) chk("R10 edge 2", cpu_irq, 0);
    @(negedge clk) chk("R10 edge 3", cpu_irq, 1);
    rd("R5 edge read", 8'h6C, 17);
    wr(8'hB4, 17);
    chk("R7 latch cleared", cpu_irq, 0);
    @(negedge clk) priv_irq[17] = 0;
    repeat (3) @(negedge clk);
    priv_irq[17] = 1;
    repeat (3) @(negedge clk);
    chk("R7 relatched", cpu_irq, 1);
    priv_irq[17] = 0;
    repeat (3) @(negedge clk);
    chk("R4 rising ignores fall", cpu_irq, 1);
    priv_irq[17] = 1;
    @(negedge clk);
    rd("R7 collide read", 8'h6C, 17);
    wr(8'hB4, 17);
    chk("R7 kept edge", cpu_irq, 1);
    rd("R7 kept edge read", 8'h6C, 17);
    wr(8'hB4, 17);
    chk("R7 drained", cpu_irq, 0);
    wr(8'hA4, 17);
    priv_irq[17] = 0;
    // falling edge on 3: word 0x14 bits 7:6 = 3
    priv_irq[3] = 1;
    repeat (4) @(negedge clk);
    wr(8'hA0, 3);
    chk("R4 falling ignores rise", cpu_irq, 0);
    priv_irq[3] = 0;
    repeat (3) @(negedge clk);
    chk("R4 falling latched", cpu_irq, 1);
    rd("R4 falling read", 8'h6C, 3);
    wr(8'hB4, 3);
    wr(8'hA4, 3);
    // shared request with private competitor
    shr_valid = 1; shr_id = 45;
    wr(8'hA0, 2);
    priv_irq[2] = 1;
    rd("R5 private before shared", 8'h6C, 2);
    rd("R8 shared read", 8'h6C, 45);
    chk("R8 shared active", cpu_irq, 0);
    wr(8'hB4, 45);
    chk("R8 shared after completion", cpu_irq, 1);
    rd("R8 shared again", 8'h6C, 45);
    wr(8'hB4, 45);
    shr_valid = 0;
    wr(8'hB4, 2);
    wr(8'h00, 0);
    chk("R2 disabled irq", cpu_irq, 0);
    rd("R2 disabled ready", 8'h6C, 32'h3FF);
    priv_irq[2] = 0;
    // IPI
    wr(8'h60, 32'h0000A50F);
    chk("R9 ipi req", ipi_req, 1);
    chk("R9 ipi id", ipi_id, 4'hF);
    chk("R9 ipi mask", ipi_mask, 8'hA5);
    @(negedge clk) chk("R9 ipi one cycle", ipi_req, 0);
    rd("R11 unmapped", 8'h40, 0);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule